// File: doc/BRIEF.md
# USB Host Transaction Error Tracker

This block checks the result of each transaction that a USB host controller's queue engine completes, and keeps the error state of the active queue entry. A one-cycle result strobe carries an outcome code together with three qualifiers: whether the token was SETUP, whether the endpoint is high-speed, and whether the transaction was a complete-split. From these the block updates a 2-bit retry countdown, a transaction-error flag, a babble flag and a halted flag for the entry.

The block does not raise an interrupt on every error. It marks an error interrupt as pending only when the entry halts, either because the retry countdown runs out (1 to 0) or because the device babbled. A pending error reaches the status bit at the next interrupt-threshold boundary, which is a programmable number of frame ticks. The status bit drives the interrupt line and stays set until software writes a one to clear it.

Software starts the entry with a load strobe that supplies the first countdown value. A halted entry ignores further results until the next load.

Top module: `xact_err_tracker`

## Requirements
- R1: After reset the countdown is 3, and the transaction-error, babble, halted and status outputs are all 0.
- R2: An accepted result with code 1 (CRC), 2 (timeout) or 3 (unrecognized PID) sets `xact_err` and lowers `cerr` by one on the next clock.
- R3: Code 6 (NAK) with `res_setup` and `res_hs` high, code 7 (NYET) with `res_setup` and `res_hs` high, and code 6 with `res_hs` low and `res_csplit` high are protocol errors and act as in R2. Code 0 (ACK), and a NAK or NYET without these qualifiers, change nothing.
- R4: When a counted error meets `cerr` = 1, the countdown goes to 0, the entry halts and an error becomes pending. When `cerr` is already 0 it stays at 0, and a counted error only sets `xact_err`.
- R5: Code 4 (babble) sets `babble` and `halted` and makes an error pending, and leaves `cerr` unchanged.
- R6: Code 5 (buffer error) sets `xact_err` only. `cerr` and `halted` do not change.
- R7: While `halted` is high, result strobes change nothing. `entry_load` loads `load_cerr` into `cerr` and clears `xact_err`, `babble` and `halted`, and it takes priority over a result in the same cycle.
- R8: A pending error sets `err_sts` only at a threshold boundary. A boundary is the frame tick that brings the tick count since the last boundary up to `irq_thr`, and a value of 0 behaves as 1. An error that becomes pending in the cycle of a boundary waits for the next boundary.
- R9: A write with `sts_wr` high and `sts_wdata` 1 clears `err_sts`. A write of 0 has no effect. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| entry_load | input | 1 | Initialize the queue entry; clears the halt |
| load_cerr | input | 2 | Countdown value loaded by `entry_load` |
| res_vld | input | 1 | One-cycle transaction result strobe |
| res_code | input | 3 | Outcome code: 0 ACK, 1 CRC, 2 timeout, 3 bad PID, 4 babble, 5 buffer error, 6 NAK, 7 NYET |
| res_setup | input | 1 | The token was SETUP |
| res_hs | input | 1 | The endpoint is high-speed |
| res_csplit | input | 1 | The transaction was a complete-split |
| frame_tick | input | 1 | One-cycle frame tick |
| irq_thr | input | 8 | Interrupt threshold in frame ticks |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 1 | Write data; 1 clears the status bit |
| cerr | output | 2 | Error countdown of the entry |
| xact_err | output | 1 | Transaction-error flag |
| babble | output | 1 | Babble-detected flag |
| halted | output | 1 | The entry is halted |
| err_sts | output | 1 | Latched error interrupt status, which is also the interrupt line |

## Verification
A wrong countdown shows on `cerr` in the cycle after the result that caused it. It also shows later, when `halted` rises one error too early or too late and every following strobe is then ignored or wrongly accepted. A lost or duplicated pending error stays hidden until the next threshold boundary, where `err_sts` fails to rise or rises with no cause, which can be many frame ticks after the error itself. The bench therefore compares all outputs with a behavioural model on every clock and steps through boundaries on purpose, so that these delayed faults show up.

// File: rtl/xe_pkg.sv
package xe_pkg;

  typedef enum logic [2:0] {
    XE_ACK    = 3'd0,
    XE_CRC    = 3'd1,
    XE_TMO    = 3'd2,
    XE_BADPID = 3'd3,
    XE_BABBLE = 3'd4,
    XE_BUFERR = 3'd5,
    XE_NAK    = 3'd6,
    XE_NYET   = 3'd7
  } xe_code_e;

  typedef struct packed {
    logic count_err;
    logic babble;
    logic buf_err;
  } xe_class_t;

  // Sort one outcome into the three kinds of effect it can have.
  function automatic xe_class_t xe_classify(input xe_code_e c, input logic setup,
                                            input logic hs, input logic csplit);
    xe_class_t r;
    r = '0;
    case (c)
      XE_CRC, XE_TMO, XE_BADPID: r.count_err = 1'b1;
      XE_BABBLE:                 r.babble    = 1'b1;
      XE_BUFERR:                 r.buf_err   = 1'b1;
      XE_NAK:                    r.count_err = (hs & setup) | (~hs & csplit);
      XE_NYET:                   r.count_err = hs & setup;
      default:                   r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xe_decode.sv
module xe_decode
  import xe_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              res_vld,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_setup,
  input  logic              res_hs,
  input  logic              res_csplit,
  output logic              evt_cnt,
  output logic              evt_bab,
  output logic              evt_buf
);

  xe_class_t cls;

  always_comb begin
    cls     = xe_classify(xe_code_e'(res_code), res_setup, res_hs, res_csplit);
    evt_cnt = res_vld & cls.count_err;
    evt_bab = res_vld & cls.babble;
    evt_buf = res_vld & cls.buf_err;
  end

endmodule

// File: rtl/xe_entry.sv
module xe_entry #(
  parameter int CERR_W    = 2,
  parameter int CERR_INIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_load,
  input  logic [CERR_W-1:0] load_cerr,
  input  logic              evt_cnt,
  input  logic              evt_bab,
  input  logic              evt_buf,
  output logic [CERR_W-1:0] cerr,
  output logic              xact_err,
  output logic              babble,
  output logic              halted,
  output logic              halt_evt
);

  localparam logic [CERR_W-1:0] INIT_V = CERR_W'(CERR_INIT);
  localparam logic [CERR_W-1:0] ONE_V  = CERR_W'(1);

  // Countdown that stops at zero; a zero count no longer counts.
  function automatic logic [CERR_W-1:0] cerr_step(input logic [CERR_W-1:0] v);
    return (v == '0) ? v : v - ONE_V;
  endfunction

  logic accept;
  logic exhaust;

  assign accept   = ~entry_load & ~halted;
  assign exhaust  = accept & evt_cnt & (cerr == ONE_V);
  assign halt_evt = exhaust | (accept & evt_bab);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cerr     <= INIT_V;
      xact_err <= 1'b0;
      babble   <= 1'b0;
      halted   <= 1'b0;
    end else if (entry_load) begin
      cerr     <= load_cerr;
      xact_err <= 1'b0;
      babble   <= 1'b0;
      halted   <= 1'b0;
    end else if (accept) begin
      if (evt_cnt) begin
        xact_err <= 1'b1;
        cerr     <= cerr_step(cerr);
      end
      if (evt_buf) xact_err <= 1'b1;
      if (evt_bab) babble   <= 1'b1;
      if (halt_evt) halted  <= 1'b1;
    end
  end

endmodule

// File: rtl/xe_irq.sv
module xe_irq #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [THR_W-1:0] irq_thr,
  input  logic             src,
  input  logic             sts_wr,
  input  logic             sts_wdata,
  output logic             thr_hit,
  output logic             pend,
  output logic             err_sts
);

  localparam int CW = THR_W + 1;

  logic [THR_W-1:0] tick_cnt;
  logic             clr_req;

  // A boundary is the tick that makes the count reach the threshold; zero acts as one.
  assign thr_hit = frame_tick & (({1'b0, tick_cnt} + CW'(1)) >= {1'b0, irq_thr});
  assign clr_req = sts_wr & sts_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pend     <= 1'b0;
      err_sts  <= 1'b0;
    end else begin
      if (thr_hit)         tick_cnt <= '0;
      else if (frame_tick) tick_cnt <= tick_cnt + 1'b1;
      pend    <= (pend & ~thr_hit) | src;
      err_sts <= (err_sts & ~clr_req) | (thr_hit & pend);
    end
  end

endmodule

// File: rtl/xact_err_tracker.sv
module xact_err_tracker #(
  parameter int CERR_W    = 2,
  parameter int CERR_INIT = 3,
  parameter int THR_W     = 8,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_load,
  input  logic [CERR_W-1:0] load_cerr,
  input  logic              res_vld,
  input  logic [CODE_W-1:0] res_code,
  input  logic              res_setup,
  input  logic              res_hs,
  input  logic              res_csplit,
  input  logic              frame_tick,
  input  logic [THR_W-1:0]  irq_thr,
  input  logic              sts_wr,
  input  logic              sts_wdata,
  output logic [CERR_W-1:0] cerr,
  output logic              xact_err,
  output logic              babble,
  output logic              halted,
  output logic              err_sts
);

  logic evt_cnt;
  logic evt_bab;
  logic evt_buf;
  logic halt_evt;
  logic thr_hit;
  logic pend;

  xe_decode #(.CODE_W(CODE_W)) u_dec (
    .res_vld   (res_vld),
    .res_code  (res_code),
    .res_setup (res_setup),
    .res_hs    (res_hs),
    .res_csplit(res_csplit),
    .evt_cnt   (evt_cnt),
    .evt_bab   (evt_bab),
    .evt_buf   (evt_buf)
  );

  xe_entry #(.CERR_W(CERR_W), .CERR_INIT(CERR_INIT)) u_ent (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_load(entry_load),
    .load_cerr (load_cerr),
    .evt_cnt   (evt_cnt),
    .evt_bab   (evt_bab),
    .evt_buf   (evt_buf),
    .cerr      (cerr),
    .xact_err  (xact_err),
    .babble    (babble),
    .halted    (halted),
    .halt_evt  (halt_evt)
  );

  xe_irq #(.THR_W(THR_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .irq_thr   (irq_thr),
    .src       (halt_evt),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .thr_hit   (thr_hit),
    .pend      (pend),
    .err_sts   (err_sts)
  );

endmodule

// File: rtl/xe_chk.sv
module xe_chk #(
  parameter int CERR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              entry_load,
  input logic [CERR_W-1:0] load_cerr,
  input logic              sts_wr,
  input logic              sts_wdata,
  input logic [CERR_W-1:0] cerr,
  input logic              xact_err,
  input logic              babble,
  input logic              halted,
  input logic              err_sts,
  input logic              thr_hit,
  input logic              pend
);

  // R7
  halted_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !entry_load) |=> (halted && $stable(cerr) && $stable(xact_err) && $stable(babble)));

  // R7
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_load |=> (cerr == $past(load_cerr) && !halted && !xact_err && !babble));

  // R4
  cerr_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_load |=> (cerr <= $past(cerr)));

  // R4
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (babble || (cerr == '0 && $past(cerr) == CERR_W'(1))));

  // R8
  sts_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sts) |-> $past(thr_hit && pend));

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_wdata && !(thr_hit && pend)) |=> !err_sts);

endmodule

bind xact_err_tracker xe_chk #(.CERR_W(CERR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .entry_load(entry_load),
  .load_cerr (load_cerr),
  .sts_wr    (sts_wr),
  .sts_wdata (sts_wdata),
  .cerr      (cerr),
  .xact_err  (xact_err),
  .babble    (babble),
  .halted    (halted),
  .err_sts   (err_sts),
  .thr_hit   (thr_hit),
  .pend      (pend)
);

// File: tb/sim_xact_err_tracker.sv
`timescale 1ns/1ps
module sim_xact_err_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       entry_load = 1'b0;
  logic [1:0] load_cerr = 2'd3;
  logic       res_vld = 1'b0;
  logic [2:0] res_code = 3'd0;
  logic       res_setup = 1'b0;
  logic       res_hs = 1'b0;
  logic       res_csplit = 1'b0;
  logic       frame_tick = 1'b0;
  logic [7:0] irq_thr = 8'd4;
  logic       sts_wr = 1'b0;
  logic       sts_wdata = 1'b0;
  logic [1:0] cerr;
  logic       xact_err, babble, halted, err_sts;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  // reference model state
  int m_cerr = 3, m_xe = 0, m_bab = 0, m_halt = 0, m_pend = 0, m_sts = 0, m_cnt = 0;

  always #10 clk = ~clk;

  xact_err_tracker u0 (
    .clk(clk), .rst_n(rst_n), .entry_load(entry_load), .load_cerr(load_cerr),
    .res_vld(res_vld), .res_code(res_code), .res_setup(res_setup), .res_hs(res_hs),
    .res_csplit(res_csplit), .frame_tick(frame_tick), .irq_thr(irq_thr),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .cerr(cerr), .xact_err(xact_err),
    .babble(babble), .halted(halted), .err_sts(err_sts)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit counted, boundary, ev;
    int lim, n_sts;
    counted = 0; boundary = 0; ev = 0;
    if (res_vld) begin
      if (res_code >= 1 && res_code <= 3) counted = 1;
      if (res_code == 6 && ((res_hs && res_setup) || (!res_hs && res_csplit))) counted = 1;
      if (res_code == 7 && res_hs && res_setup) counted = 1;
    end
    lim = (irq_thr == 0) ? 1 : int'(irq_thr);
    if (frame_tick) begin
      if (m_cnt + 1 >= lim) begin boundary = 1; m_cnt = 0; end
      else m_cnt++;
    end
    n_sts = ((m_sts != 0) && !(sts_wr && sts_wdata)) || (boundary && m_pend != 0);
    if (entry_load) begin
      m_cerr = int'(load_cerr); m_xe = 0; m_bab = 0; m_halt = 0;
    end else if (m_halt == 0 && res_vld) begin
      if (counted) begin
        m_xe = 1;
        if (m_cerr == 1) begin ev = 1; m_halt = 1; end
        if (m_cerr > 0) m_cerr--;
      end
      if (res_code == 5) m_xe = 1;
      if (res_code == 4) begin m_bab = 1; m_halt = 1; ev = 1; end
    end
    m_pend = ((m_pend != 0) && !boundary) || ev;
    m_sts = n_sts;
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    if (rst_n) begin
      chk(tag, "cerr", int'(cerr), m_cerr);
      chk(tag, "xact_err", int'(xact_err), m_xe);
      chk(tag, "babble", int'(babble), m_bab);
      chk(tag, "halted", int'(halted), m_halt);
      chk(tag, "err_sts", int'(err_sts), m_sts);
    end
  endtask

  task automatic res(input logic [2:0] c, input logic s, input logic h, input logic cs);
    res_vld = 1; res_code = c; res_setup = s; res_hs = h; res_csplit = cs;
    cyc();
    res_vld = 0; res_code = 0; res_setup = 0; res_hs = 0; res_csplit = 0;
  endtask

  task automatic load(input logic [1:0] v);
    entry_load = 1; load_cerr = v;
    cyc();
    entry_load = 0;
  endtask

  task automatic tick();
    frame_tick = 1; cyc(); frame_tick = 0;
  endtask

  task automatic wr(input logic d);
    sts_wr = 1; sts_wdata = d; cyc(); sts_wr = 0; sts_wdata = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    cyc(); cyc();
    chk("R1", "cerr reset", int'(cerr), 3);
    chk("R1", "status reset", int'(err_sts | halted | xact_err | babble), 0);

    tag = "R2";
    res(3'd1, 0, 0, 0);
    chk("R2", "crc cerr", int'(cerr), 2);
    chk("R2", "crc xact_err", int'(xact_err), 1);
    load(2'd3);
    res(3'd2, 0, 1, 0);
    res(3'd3, 1, 0, 0);
    chk("R2", "timeout+pid cerr", int'(cerr), 1);

    tag = "R4";
    res(3'd1, 0, 0, 0);
    chk("R4", "exhaust cerr", int'(cerr), 0);
    chk("R4", "exhaust halted", int'(halted), 1);

    tag = "R8";
    tick(); tick(); tick();
    chk("R8", "before boundary", int'(err_sts), 0);
    tick();
    chk("R8", "at boundary", int'(err_sts), 1);

    tag = "R9";
    wr(1'b0);
    chk("R9", "write zero", int'(err_sts), 1);
    wr(1'b1);
    chk("R9", "write one", int'(err_sts), 0);

    tag = "R7";
    res(3'd1, 0, 0, 0);
    res(3'd4, 0, 0, 0);
    chk("R7", "halted ignores babble", int'(babble), 0);
    chk("R7", "halted keeps cerr", int'(cerr), 0);
    load(2'd3);
    chk("R7", "load cerr", int'(cerr), 3);
    chk("R7", "load clears halt", int'(halted), 0);
    entry_load = 1; load_cerr = 2'd2; res(3'd1, 0, 0, 0); entry_load = 0;
    chk("R7", "load beats result", int'(cerr), 2);
    chk("R7", "load beats result xe", int'(xact_err), 0);
    load(2'd3);

    tag = "R3";
    res(3'd6, 1, 1, 0);
    chk("R3", "hs setup nak", int'(cerr), 2);
    res(3'd7, 1, 1, 0);
    chk("R3", "hs setup nyet", int'(cerr), 1);
    load(2'd3);
    res(3'd6, 0, 1, 0);
    res(3'd7, 0, 1, 1);
    res(3'd6, 0, 0, 0);
    res(3'd7, 1, 0, 1);
    res(3'd0, 1, 1, 0);
    chk("R3", "non-error handshakes cerr", int'(cerr), 3);
    chk("R3", "non-error handshakes xe", int'(xact_err), 0);
    res(3'd6, 0, 0, 1);
    chk("R3", "fs csplit nak", int'(cerr), 2);

    tag = "R6";
    load(2'd3);
    res(3'd5, 0, 0, 0);
    chk("R6", "buffer err xe", int'(xact_err), 1);
    chk("R6", "buffer err cerr", int'(cerr), 3);
    chk("R6", "buffer err halt", int'(halted), 0);

    tag = "R5";
    res(3'd4, 0, 1, 0);
    chk("R5", "babble bit", int'(babble), 1);
    chk("R5", "babble halt", int'(halted), 1);
    chk("R5", "babble cerr", int'(cerr), 3);

    tag = "R8";
    irq_thr = 8'd0;
    tick();
    chk("R8", "thr zero boundary", int'(err_sts), 1);
    wr(1'b1);

    tag = "R4";
    load(2'd0);
    res(3'd1, 0, 0, 0);
    chk("R4", "zero stays", int'(cerr), 0);
    chk("R4", "zero no halt", int'(halted), 0);
    chk("R4", "zero xe", int'(xact_err), 1);
    tick();
    chk("R4", "zero no pending", int'(err_sts), 0);

    tag = "R8";
    load(2'd1);
    frame_tick = 1; res(3'd2, 0, 0, 0); frame_tick = 0;
    chk("R8", "same-cycle event waits", int'(err_sts), 0);
    tag = "R9";
    sts_wr = 1; sts_wdata = 1; tick(); sts_wr = 0; sts_wdata = 0;
    chk("R9", "set wins over clear", int'(err_sts), 1);
    wr(1'b1);
    cyc(); cyc();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule